// File: doc/BRIEF.md
# Serial bank register loader

This block collects register values for a memory bank switcher one bit per CPU write. Any enabled write whose address has its top bit set feeds the loader. If bit 7 of the data byte is clear, data bit 0 is shifted in, least-significant bit first. The fifth such write completes a 5-bit value. That value goes to one of four registers, chosen by the two address bits just below the top bit.

A write with data bit 7 set cancels a partial value. It also forces two program-mode bits in the control register high. The four registers drive the address-translation logic directly, as plain outputs.

All updates happen on the rising clock edge that samples the write strobe, so each result shows at the outputs one cycle after the write is presented.

Top module: `serial_bank_loader`

## Requirements
- R1: After reset, `ctrl_q` reads 0x0C, and `chr0_q`, `chr1_q` and `prg_q` read 0.
- R2: A cycle with `wr_en` low, or with `wr_addr[15]` equal to 0, changes no output and no partial value, whatever the data byte holds (bit 7 included).
- R3: A write with `wr_addr[15]`=1 and `wr_data[7]`=1 discards any partial value. It sets `ctrl_q[3:2]` to 2'b11, leaves `ctrl_q[4]`, `ctrl_q[1:0]` and the three bank registers unchanged, and commits no value.
- R4: With `wr_data[7]`=0, the n-th write of a sequence (n = 0..4) supplies bit n of the committed value from `wr_data[0]`.
- R5: The fifth write's `wr_addr[14:13]` picks the destination: 0 → `ctrl_q`, 1 → `chr0_q`, 2 → `chr1_q`, 3 → `prg_q`. Address bits of the first four writes have no effect, and the other three registers keep their values.
- R6: After a commit or an abort, the next five loading writes form a complete new value, free of earlier bits.
- R7: Data bits 6:1 of a loading write have no effect on any register.
- R8: No register changes on the first to fourth loading writes of a sequence. The commit happens on exactly the fifth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | CPU write strobe, one write per cycle while high |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| ctrl_q | output | 5 | Control register (mirroring and program/character modes) |
| chr0_q | output | 5 | Character bank 0 register |
| chr1_q | output | 5 | Character bank 1 register |
| prg_q | output | 5 | Program bank register |

## Verification
Every write, abort and commit lands in the registers at the rising edge that samples it, so each result is due exactly one cycle after the write is presented. The bench applies each write at a falling edge and drops the strobe at the next falling edge. At that same point it compares all four outputs with its own model, half a period after the edge that should have updated them. Because the outputs are checked after every write, a commit that comes one write early or late shows up at once, as do a stray update from an ignored cycle and a lost abort.

// File: rtl/serial_bank_loader.sv
module serial_bank_loader #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int VAL_W      = 5,
  parameter int ABORT_BIT  = 7,
  parameter int CTRL_INIT  = 12,
  parameter int ABORT_MASK = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [VAL_W-1:0]  ctrl_q,
  output logic [VAL_W-1:0]  chr0_q,
  output logic [VAL_W-1:0]  chr1_q,
  output logic [VAL_W-1:0]  prg_q
);
  localparam int CNT_W = $clog2(VAL_W);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(VAL_W - 1);
  localparam logic [VAL_W-1:0] CTRL_RST = VAL_W'(CTRL_INIT);
  localparam logic [VAL_W-1:0] FORCE_SET = VAL_W'(ABORT_MASK);

  logic [VAL_W-2:0] sr;
  logic [CNT_W-1:0] cnt;

  wire hit   = wr_en && wr_addr[ADDR_W-1];
  wire abort = hit && wr_data[ABORT_BIT];
  wire load  = hit && !wr_data[ABORT_BIT];
  wire last  = load && (cnt == LAST_CNT);
  wire [1:0] sel = wr_addr[ADDR_W-2:ADDR_W-3];
  wire [VAL_W-1:0] full = {wr_data[0], sr};
  wire [VAL_W-2:0] bit_in = {{(VAL_W-2){1'b0}}, wr_data[0]} << cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      cnt    <= '0;
      ctrl_q <= CTRL_RST;
      chr0_q <= '0;
      chr1_q <= '0;
      prg_q  <= '0;
    end else if (abort) begin
      sr     <= '0;
      cnt    <= '0;
      ctrl_q <= ctrl_q | FORCE_SET;
    end else if (last) begin
      sr  <= '0;
      cnt <= '0;
      case (sel)
        2'd0:    ctrl_q <= full;
        2'd1:    chr0_q <= full;
        2'd2:    chr1_q <= full;
        default: prg_q  <= full;
      endcase
    end else if (load) begin
      sr  <= sr | bit_in;
      cnt <= cnt + 1'b1;
    end
  end

  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST_CNT);

  // R3
  abort_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> ((ctrl_q & FORCE_SET) == FORCE_SET) && (cnt == '0)
              && $stable(chr0_q) && $stable(chr1_q) && $stable(prg_q));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(ctrl_q) && $stable(chr0_q) && $stable(chr1_q)
             && $stable(prg_q) && $stable(cnt) && $stable(sr));

  // R6
  commit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (cnt == '0) && (sr == '0));

  // R5
  prg_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last && sel == 2'd3) |=> prg_q == $past(full));

  // R5
  chr0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(last && sel == 2'd1) |=> $stable(chr0_q));

  // R8
  early_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !last) |=> $stable(ctrl_q) && $stable(chr0_q)
                        && $stable(chr1_q) && $stable(prg_q));
endmodule

// File: tb/serial_bank_loader_tb.sv
`timescale 1ns/1ps
module serial_bank_loader_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [4:0]  ctrl_q, chr0_q, chr1_q, prg_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [4:0] m_sr, m_ctrl, m_chr0, m_chr1, m_prg;
  int m_cnt;

  always #2.5 clk = ~clk;

  serial_bank_loader u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl_q(ctrl_q), .chr0_q(chr0_q),
    .chr1_q(chr1_q), .prg_q(prg_q)
  );

  function automatic logic [4:0] with_bit(logic [4:0] v, int pos, logic b);
    logic [4:0] r = v;
    r[pos] = b;
    return r;
  endfunction

  task automatic model_reset();
    m_sr = 0; m_cnt = 0; m_ctrl = 5'h0C; m_chr0 = 0; m_chr1 = 0; m_prg = 0;
  endtask

  task automatic model_write(logic en, logic [15:0] a, logic [7:0] d);
    if (!en || !a[15]) return;
    if (d[7]) begin
      m_sr = 0; m_cnt = 0; m_ctrl = m_ctrl | 5'h0C;
      return;
    end
    m_sr = with_bit(m_sr, m_cnt, d[0]);
    m_cnt++;
    if (m_cnt == 5) begin
      case (a[14:13])
        2'd0: m_ctrl = m_sr;
        2'd1: m_chr0 = m_sr;
        2'd2: m_chr1 = m_sr;
        default: m_prg = m_sr;
      endcase
      m_sr = 0; m_cnt = 0;
    end
  endtask

  task automatic check_regs(string tag);
    checks++;
    if (ctrl_q !== m_ctrl || chr0_q !== m_chr0 || chr1_q !== m_chr1 || prg_q !== m_prg) begin
      errors++;
      $display("FAIL %s: ctrl/chr0/chr1/prg got %h/%h/%h/%h expected %h/%h/%h/%h",
               tag, ctrl_q, chr0_q, chr1_q, prg_q, m_ctrl, m_chr0, m_chr1, m_prg);
    end
  endtask

  task automatic do_write(logic en, logic [15:0] a, logic [7:0] d, string tag);
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_data = d;
    model_write(en, a, d);
    @(negedge clk);
    wr_en = 0;
    check_regs(tag);
  endtask

  task automatic load_value(logic [4:0] v, logic [15:0] a, string tag);
    for (int i = 0; i < 5; i++) do_write(1, a, {7'h00, v[i]}, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    check_regs("R1");
    rst_n = 1;
    @(negedge clk);
    check_regs("R1");

    // R4 / R8: bit order, nothing changes before the fifth write
    do_write(1, 16'hE000, 8'h01, "R8");
    do_write(1, 16'hE000, 8'h00, "R8");
    do_write(1, 16'hE000, 8'h00, "R8");
    do_write(1, 16'hE000, 8'h00, "R8");
    do_write(1, 16'hE000, 8'h00, "R4");
    load_value(5'h10, 16'hE123, "R4");

    // R5: each destination
    load_value(5'h13, 16'h8000, "R5");
    load_value(5'h15, 16'hA000, "R5");
    load_value(5'h0A, 16'hC000, "R5");
    load_value(5'h1E, 16'hFFFF, "R5");

    // R5: only the fifth address picks the target
    for (int i = 0; i < 4; i++) do_write(1, 16'hA000, 8'h01, "R5");
    do_write(1, 16'hC000, 8'h00, "R5");

    // R3 / R6: abort between the second and third bits
    do_write(1, 16'h8000, 8'h01, "R3");
    do_write(1, 16'h8000, 8'h01, "R3");
    do_write(1, 16'h8000, 8'h80, "R3");
    load_value(5'h04, 16'hE000, "R6");
    load_value(5'h01, 16'h8000, "R6");
    do_write(1, 16'h9000, 8'hFF, "R3");

    // R2: ignored cycles in the middle of a sequence
    do_write(1, 16'hA000, 8'h01, "R2");
    do_write(1, 16'hA000, 8'h00, "R2");
    do_write(1, 16'h7FFF, 8'h81, "R2");
    do_write(0, 16'hA000, 8'h81, "R2");
    do_write(0, 16'hA000, 8'h01, "R2");
    do_write(1, 16'hA000, 8'h01, "R2");
    do_write(1, 16'hA000, 8'h00, "R2");
    do_write(1, 16'hA000, 8'h00, "R2");

    // R7: junk in bits 6:1
    do_write(1, 16'hC000, 8'h7E, "R7");
    do_write(1, 16'hC000, 8'h41, "R7");
    do_write(1, 16'hC000, 8'h2A, "R7");
    do_write(1, 16'hC000, 8'h55, "R7");
    do_write(1, 16'hC000, 8'h3C, "R7");

    // R4: random mix
    for (int i = 0; i < 600; i++) begin
      logic [15:0] a = 16'($urandom);
      logic [7:0]  d = 8'($urandom);
      logic        e = ($urandom % 8) != 0;
      if (($urandom % 8) != 0) a[15] = 1'b1;
      if (($urandom % 8) != 0) d[7] = 1'b0;
      do_write(e, a, d, "R4");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule